// File: doc/BRIEF.md
# Countdown Timer with Selectable Tick Rate and Interrupt

This block is the countdown timer of a real-time clock. Software loads an 8-bit period into the count register and picks one of four tick rates (4096 Hz, 64 Hz, 1 Hz or one tick per minute) in the timer register. The rates arrive as single-cycle tick enables from a prescaler outside the block. Each tick of the chosen rate lowers the count by one while the timer is enabled. When the count reaches zero the timer sets its flag, reloads the period and keeps running.

The interrupt output is active low and has two modes. In level mode it stays low as long as the flag and the interrupt enable are both set, so software must clear the flag to release it. In pulse mode it goes low at expiry and returns high at the next tick of the chosen rate. The flag, the interrupt enable and the mode bit are in the second control register, at address 0x01.

Top module: `cdt_timer`

## Requirements
- R1: After reset, addresses 0x01, 0x0E and 0x0F all read 0x00 and `int_n` is high.
- R2: Bits 1:0 of register 0x0E select the tick source. Code 0 selects `src_tick[0]` (4096 Hz), 1 selects `src_tick[1]` (64 Hz), 2 selects `src_tick[2]` (1 Hz) and 3 selects `src_tick[3]` (1/60 Hz). Ticks on the other inputs have no effect on the count.
- R3: Bit 3 of 0x0E enables counting. While it is clear, the count holds the loaded period and ignores every tick, and the flag does not change except through writes.
- R4: With a period N (from 1 to 255) loaded, the N-th selected tick after loading sets the flag and reloads N into the count. Counting then continues with the same period.
- R5: Bit 2 of 0x01 is the timer flag. Writing 0 to it clears the flag and writing 1 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R6: Level mode (bit 4 of 0x01 clear): `int_n` is low exactly while the flag and the interrupt enable (bit 0 of 0x01) are both set.
- R7: Pulse mode (bit 4 of 0x01 set, bit 0 set): `int_n` goes low at expiry and returns high at the next selected tick that is not itself an expiry. Ticks on other inputs do not end the pulse.
- R8: A write to 0x0F stores the new period and loads it into the count at once, whether or not the timer is enabled.
- R9: With a period of zero the count stays at zero and the flag is never set, however many ticks arrive.
- R10: Reads are combinational. 0x0E returns {4'b0, enable, 1'b0, source}. 0x01 returns bits 0, 2 and 4 with all other bits 0. 0x0F returns the current count. Every other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| src_tick | input | 4 | Single-cycle tick enables, one per rate |
| int_n | output | 1 | Active-low timer interrupt |

## Verification
The hardest case to reach is an expiry in the same clock cycle as a write that clears the flag. The bench gets there by loading a period of one, so every selected tick expires, and then raising the tick and the clearing write on the same falling edge. The end of a pulse-mode interrupt is also hard to observe. The bench checks that ticks on unselected inputs leave `int_n` low, and that exactly one tick of the chosen rate releases it.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_SRC = 4;
  localparam int SRC_W   = $clog2(NUM_SRC);

  localparam logic [ADDR_W-1:0] ADDR_CTL2 = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_TMR  = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 4'hF;

  localparam int CTL2_TIE_BIT   = 0;
  localparam int CTL2_FLAG_BIT  = 2;
  localparam int CTL2_PULSE_BIT = 4;
  localparam int TMR_EN_BIT     = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_4096HZ = 2'd0,
    SRC_64HZ   = 2'd1,
    SRC_1HZ    = 2'd2,
    SRC_MINUTE = 2'd3
  } src_e;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               sel_tick
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = src_tick[i] & (sel == SEL_W'(i));
  end

  assign sel_tick = |hit;
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] period,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q,
  output logic         expire
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] count_d;
  logic         step;

  assign step   = run & tick & ~load & (count_q != ZERO);
  assign expire = step & (count_q == ONE);

  always_comb begin
    count_d = count_q;
    if (load)        count_d = load_val;
    else if (!run)   count_d = period;
    else if (expire) count_d = period;
    else if (step)   count_d = count_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) count_q <= ZERO;
    else         count_q <= count_d;
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_sn,
  input  logic expire,
  input  logic sel_tick,
  input  logic irq_en,
  input  logic pulse_mode,
  input  logic flag_clr,
  output logic flag_q,
  output logic int_n
);
  logic flag_d;
  logic pulse_q, pulse_d;

  always_comb begin
    flag_d = flag_q;
    if (expire)        flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_comb begin
    pulse_d = pulse_q;
    if (!irq_en || !pulse_mode) pulse_d = 1'b0;
    else if (expire)            pulse_d = 1'b1;
    else if (sel_tick)          pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign int_n = pulse_mode ? ~pulse_q : ~(flag_q & irq_en);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic              int_n
);
  logic rst_sn;

  // register state
  logic              tie_q, tie_d;
  logic              pm_q, pm_d;
  logic              en_q, en_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic [DATA_W-1:0] reload_q, reload_d;

  logic wr_ctl2, wr_tmr, wr_cnt;
  logic sel_tick, expire, flag_q;
  logic [DATA_W-1:0] count_q;

  cdt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign wr_ctl2 = wr_en & (addr == ADDR_CTL2);
  assign wr_tmr  = wr_en & (addr == ADDR_TMR);
  assign wr_cnt  = wr_en & (addr == ADDR_CNT);

  always_comb begin
    tie_d    = tie_q;
    pm_d     = pm_q;
    en_d     = en_q;
    src_d    = src_q;
    reload_d = reload_q;
    if (wr_ctl2) begin
      tie_d = wdata[CTL2_TIE_BIT];
      pm_d  = wdata[CTL2_PULSE_BIT];
    end
    if (wr_tmr) begin
      en_d  = wdata[TMR_EN_BIT];
      src_d = wdata[SRC_W-1:0];
    end
    if (wr_cnt) reload_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tie_q    <= 1'b0;
      pm_q     <= 1'b0;
      en_q     <= 1'b0;
      src_q    <= SRC_4096HZ;
      reload_q <= '0;
    end else begin
      tie_q    <= tie_d;
      pm_q     <= pm_d;
      en_q     <= en_d;
      src_q    <= src_d;
      reload_q <= reload_d;
    end
  end

  cdt_tick_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_tick (src_tick),
    .sel      (src_q),
    .sel_tick (sel_tick)
  );

  cdt_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .run      (en_q),
    .tick     (sel_tick),
    .period   (reload_q),
    .load     (wr_cnt),
    .load_val (wdata),
    .count_q  (count_q),
    .expire   (expire)
  );

  cdt_irq u_irq (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .expire     (expire),
    .sel_tick   (sel_tick),
    .irq_en     (tie_q),
    .pulse_mode (pm_q),
    .flag_clr   (wr_ctl2 & ~wdata[CTL2_FLAG_BIT]),
    .flag_q     (flag_q),
    .int_n      (int_n)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTL2: begin
        rdata[CTL2_TIE_BIT]   = tie_q;
        rdata[CTL2_FLAG_BIT]  = flag_q;
        rdata[CTL2_PULSE_BIT] = pm_q;
      end
      ADDR_TMR: begin
        rdata[TMR_EN_BIT]  = en_q;
        rdata[SRC_W-1:0]   = src_q;
      end
      ADDR_CNT: rdata = count_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
  import cdt_pkg::*;
(
  input logic              clk,
  input logic              rst_sn,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              int_n,
  input logic              en_q,
  input logic              tie_q,
  input logic              pm_q,
  input logic [DATA_W-1:0] reload_q,
  input logic [DATA_W-1:0] count_q,
  input logic              flag_q,
  input logic              expire,
  input logic              sel_tick
);
  logic cnt_wr;
  assign cnt_wr = wr_en & (addr == ADDR_CNT);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (expire && !cnt_wr) |=> (count_q == $past(reload_q)));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    expire |=> flag_q);

  p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (reload_q == '0 && count_q == '0 && !cnt_wr) |=> (count_q == '0 && !$rose(flag_q)));

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!en_q && !wr_en) |=> $stable(flag_q));

  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!int_n && !pm_q && !wr_en) |=> !int_n);

  p_pulse_end_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (pm_q && tie_q && !int_n && sel_tick && !expire && !wr_en) |=> int_n);
endmodule

bind cdt_timer cdt_timer_chk u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .wr_en    (wr_en),
  .addr     (addr),
  .int_n    (int_n),
  .en_q     (en_q),
  .tie_q    (tie_q),
  .pm_q     (pm_q),
  .reload_q (reload_q),
  .count_q  (count_q),
  .flag_q   (flag_q),
  .expire   (expire),
  .sel_tick (sel_tick)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [3:0] src_tick;
  logic       int_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cdt_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_tick(src_tick), .int_n(int_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_tick = 4'b0001 << idx;
      @(negedge clk);
      src_tick = 4'b0000;
    end
  endtask

  task automatic quiesce();
    wr(4'hE, 8'h00);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'h1, v); chk("R1 ctl2", v, 8'h00);
    rd(4'hE, v); chk("R1 tmr", v, 8'h00);
    rd(4'hF, v); chk("R1 cnt", v, 8'h00);
    chk("R1 int_n", {7'b0, int_n}, 8'h01);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(4'hE, 8'hFB); rd(4'hE, v); chk("R10 tmr en+src3", v, 8'h0B);
    wr(4'hE, 8'h02); rd(4'hE, v); chk("R10 tmr src2", v, 8'h02);
    wr(4'h1, 8'hFF); rd(4'h1, v); chk("R10 R5 ctl2 mask, flag not set by 1", v, 8'h11);
    rd(4'h7, v); chk("R10 unmapped", v, 8'h00);
    quiesce();
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr(4'hF, 8'h05);
    for (int s = 0; s < 4; s++) tick(s, 3);
    rd(4'hF, v); chk("R3 count held", v, 8'h05);
    rd(4'h1, v); chk("R3 no flag", v, 8'h00);
  endtask

  task automatic t_src_sel();
    logic [7:0] v;
    for (int s = 0; s < 4; s++) begin
      wr(4'hF, 8'h03);
      wr(4'hE, 8'h08 | 8'(s));
      for (int o = 0; o < 4; o++) if (o != s) tick(o, 2);
      rd(4'hF, v); chk($sformatf("R2 src%0d others ignored", s), v, 8'h03);
      tick(s, 1);
      rd(4'hF, v); chk($sformatf("R2 src%0d counts", s), v, 8'h02);
      wr(4'hE, 8'h00);
    end
  endtask

  task automatic t_countdown();
    logic [7:0] v;
    wr(4'hF, 8'h03);
    wr(4'hE, 8'h09);
    tick(1, 2);
    rd(4'hF, v); chk("R4 count after 2", v, 8'h01);
    rd(4'h1, v); chk("R4 no flag yet", v, 8'h00);
    tick(1, 1);
    rd(4'h1, v); chk("R4 flag at N", v, 8'h04);
    rd(4'hF, v); chk("R4 reloaded", v, 8'h03);
    wr(4'h1, 8'h04); rd(4'h1, v); chk("R5 write 1 keeps flag", v, 8'h04);
    wr(4'h1, 8'h00); rd(4'h1, v); chk("R5 write 0 clears", v, 8'h00);
    tick(1, 2);
    rd(4'h1, v); chk("R4 second period early", v, 8'h00);
    tick(1, 1);
    rd(4'h1, v); chk("R4 second period flag", v, 8'h04);
    quiesce();
  endtask

  task automatic t_level();
    wr(4'hF, 8'h02);
    wr(4'hE, 8'h09);
    tick(1, 2);
    chk("R6 enable clear keeps int_n high", {7'b0, int_n}, 8'h01);
    wr(4'h1, 8'h05);
    chk("R6 enable set gives low", {7'b0, int_n}, 8'h00);
    tick(1, 1);
    chk("R6 level holds", {7'b0, int_n}, 8'h00);
    wr(4'h1, 8'h01);
    chk("R6 clear releases", {7'b0, int_n}, 8'h01);
    quiesce();
  endtask

  task automatic t_pulse();
    logic [7:0] v;
    wr(4'h1, 8'h11);
    wr(4'hF, 8'h03);
    wr(4'hE, 8'h0A);
    tick(2, 2);
    chk("R7 high before expiry", {7'b0, int_n}, 8'h01);
    tick(2, 1);
    chk("R7 low at expiry", {7'b0, int_n}, 8'h00);
    rd(4'h1, v); chk("R7 flag set", v, 8'h15);
    tick(0, 1); tick(3, 1);
    chk("R7 other ticks keep low", {7'b0, int_n}, 8'h00);
    tick(2, 1);
    chk("R7 next tick releases", {7'b0, int_n}, 8'h01);
    rd(4'h1, v); chk("R7 flag stays", v, 8'h15);
    quiesce();
  endtask

  task automatic t_reload_write();
    logic [7:0] v;
    wr(4'hF, 8'h0A);
    wr(4'hE, 8'h09);
    tick(1, 4);
    rd(4'hF, v); chk("R8 count 6", v, 8'h06);
    wr(4'hF, 8'h07);
    rd(4'hF, v); chk("R8 immediate load", v, 8'h07);
    tick(1, 1);
    rd(4'hF, v); chk("R8 counts from new", v, 8'h06);
    quiesce();
  endtask

  task automatic t_zero();
    logic [7:0] v;
    wr(4'h1, 8'h01);
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h08);
    tick(0, 300);
    rd(4'hF, v); chk("R9 count zero", v, 8'h00);
    rd(4'h1, v); chk("R9 no flag", v, 8'h01);
    chk("R9 int_n high", {7'b0, int_n}, 8'h01);
    quiesce();
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    wr(4'hF, 8'h01);
    wr(4'hE, 8'h08);
    tick(0, 1);
    rd(4'h1, v); chk("R5 flag before race", v, 8'h04);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h1; wdata = 8'h00; src_tick = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; src_tick = 4'b0000;
    rd(4'h1, v); chk("R5 set wins over clear", v, 8'h04);
    quiesce();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; src_tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_disabled();
    t_src_sel();
    t_countdown();
    t_level();
    t_pulse();
    t_reload_write();
    t_zero();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule